// File: doc/BRIEF.md
# Program/Erase Unlock Sequence Detector

This block gates every flash program and erase operation behind a two-byte key. A programming controller reads its single output, `access_en`, and rejects write and erase commands while it is low. The flag is low after every reset. It is raised only after two strobe pulses, entered in unlock mode. The first pulse must carry 0x55 and the second must carry 0xAA. Each pulse must stay high for at least `MIN_WIDTH` clocks, which is 25 by default.

Three parts build the flag. An edge stage registers the strobe, flags its rising and falling edges, and captures the data bus on the rising edge. A width meter counts the clocks the strobe stays high. A state machine judges each pulse at its falling edge. The machine has three states:
- `SEQ_WAIT_FIRST`: waiting for the first key byte.
- `SEQ_GOT_FIRST`: the first key byte has been accepted.
- `SEQ_OPEN`: access is granted.

The transitions are named as follows:
- `T_FIRST_OK`: WAIT_FIRST to GOT_FIRST, on a long 0x55 pulse.
- `T_SECOND_OK`: GOT_FIRST to OPEN, on a long 0xAA pulse.
- `T_RESTART`: GOT_FIRST to GOT_FIRST, on a long 0x55 pulse.
- `T_BAD_KEY`: GOT_FIRST to WAIT_FIRST, on a short pulse or a wrong byte.
- `T_ABANDON`: GOT_FIRST to WAIT_FIRST, when the mode is not unlock.
- `T_LOCK`: OPEN to WAIT_FIRST, when the mode is lock.

In every other case the machine holds its state. The software flow applies lock mode after each program or erase job.

Top module: `pe_unlock_gate`

## Requirements
- R1: While reset is asserted (`rst_n` = 0) and after it is released, `access_en` is 0 and the sequence is at its start. A lone 0xAA pulse therefore does not open access.
- R2: `mode` = 2'b01 selects unlock mode. In unlock mode, a 0x55 pulse followed by a 0xAA pulse, each at least `MIN_WIDTH` clocks wide, sets `access_en`. The flag is visible after the clock edge that samples the second falling edge.
- R3: The key byte of a pulse is the value of `data_in` at the strobe's rising edge. Later changes to `data_in` during the pulse have no effect.
- R4: A pulse is counted in clocks from the rising to the falling edge of the strobe. A pulse of `MIN_WIDTH`-1 clocks is not a key and returns the sequence to its start. A pulse of `MIN_WIDTH` clocks is a key.
- R5: A long pulse carrying a byte other than the expected key returns the sequence to its start. A 0x55 pulse received while waiting for 0xAA counts as a fresh first key.
- R6: `mode` = 2'b10 selects lock mode. Lock mode clears `access_en` at the next clock edge.
- R7: When `mode` leaves 2'b01 after the first key and before the second, the partly entered sequence is abandoned.
- R8: Once set, `access_en` stays 1 under modes 2'b00, 2'b01 and 2'b11, and under any further strobe pulses, until lock mode or reset.
- R9: A pulse whose falling edge arrives while `mode` is not 2'b01 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe | input | 1 | Key strobe; data is latched on its rising edge |
| data_in | input | DATA_W | Key data bus |
| mode | input | 2 | 01 unlock, 10 lock, 00/11 hold |
| access_en | output | 1 | 1 when program/erase access is open |

## Verification
On every cycle, the assertions check four things:
- lock mode always drops the flag one edge later;
- an open flag persists until lock;
- the flag rises only right after a long 0xAA falling edge;
- the pulse counter never passes its limit, and leaving unlock mode mid-sequence returns to the start.

Only the bench's scenarios can show the rest. These are the exact width boundary at 24 and 25 clocks, capture of the byte at the rising edge rather than later, the restart on a repeated 0x55, and the ignoring of pulses that fall outside unlock mode.

// File: rtl/pe_unlock_pkg.sv
package pe_unlock_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD   = 2'b00,
        MODE_UNLOCK = 2'b01,
        MODE_LOCK   = 2'b10,
        MODE_HOLD_B = 2'b11
    } gate_mode_e;

    typedef enum logic [1:0] {
        SEQ_WAIT_FIRST = 2'b00,
        SEQ_GOT_FIRST  = 2'b01,
        SEQ_OPEN       = 2'b10
    } seq_state_e;

endpackage

// File: rtl/pe_strobe_edge.sv
module pe_strobe_edge #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic [DATA_W-1:0] data_in,
    output logic              rise,
    output logic              fall,
    output logic [DATA_W-1:0] key_byte
);

    logic strobe_q;

    // Edges are seen in the cycle where the new strobe level is first sampled.
    assign rise = strobe && !strobe_q;
    assign fall = !strobe && strobe_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_q <= 1'b0;
            key_byte <= '0;
        end else begin
            strobe_q <= strobe;
            if (rise) begin
                key_byte <= data_in;
            end
        end
    end

    // R3: captured byte only changes at a rising edge
    a_r3_byte_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> $stable(key_byte));

endmodule

// File: rtl/pe_width_meter.sv
module pe_width_meter #(
    parameter int MIN_WIDTH = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise,
    input  logic strobe,
    output logic long_enough
);

    localparam int CW = $clog2(MIN_WIDTH + 1);
    localparam logic [CW-1:0] LIMIT = CW'(MIN_WIDTH);

    logic [CW-1:0] high_cnt;

    // The rising cycle counts as the first high clock; saturate at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            high_cnt <= '0;
        end else if (rise) begin
            high_cnt <= CW'(1);
        end else if (strobe && (high_cnt < LIMIT)) begin
            high_cnt <= high_cnt + CW'(1);
        end
    end

    assign long_enough = (high_cnt >= LIMIT);

    // R4: counter never runs past its saturation limit
    a_r4_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        high_cnt <= LIMIT);

endmodule

// File: rtl/pe_key_seq.sv
module pe_key_seq
    import pe_unlock_pkg::*;
#(
    parameter int          DATA_W     = 8,
    parameter logic [7:0]  KEY_FIRST  = 8'h55,
    parameter logic [7:0]  KEY_SECOND = 8'hAA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall,
    input  logic              long_enough,
    input  logic [DATA_W-1:0] key_byte,
    input  logic [1:0]        mode,
    output logic              access_en
);

    localparam logic [DATA_W-1:0] K1 = DATA_W'(KEY_FIRST);
    localparam logic [DATA_W-1:0] K2 = DATA_W'(KEY_SECOND);

    seq_state_e state_q, state_d;
    gate_mode_e mode_e;
    logic       judge;
    logic       is_first;
    logic       is_second;

    assign mode_e    = gate_mode_e'(mode);
    assign judge     = fall && (mode_e == MODE_UNLOCK);
    assign is_first  = long_enough && (key_byte == K1);
    assign is_second = long_enough && (key_byte == K2);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_WAIT_FIRST: begin
                if (judge && is_first) begin
                    state_d = SEQ_GOT_FIRST;          // T_FIRST_OK
                end
            end
            SEQ_GOT_FIRST: begin
                if (mode_e != MODE_UNLOCK) begin
                    state_d = SEQ_WAIT_FIRST;         // T_ABANDON
                end else if (judge) begin
                    if (is_second) begin
                        state_d = SEQ_OPEN;           // T_SECOND_OK
                    end else if (is_first) begin
                        state_d = SEQ_GOT_FIRST;      // T_RESTART
                    end else begin
                        state_d = SEQ_WAIT_FIRST;     // T_BAD_KEY
                    end
                end
            end
            SEQ_OPEN: begin
                if (mode_e == MODE_LOCK) begin
                    state_d = SEQ_WAIT_FIRST;         // T_LOCK
                end
            end
            default: state_d = SEQ_WAIT_FIRST;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_WAIT_FIRST;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register, loaded from the next state so lock acts in one edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            access_en <= 1'b0;
        end else begin
            access_en <= (state_d == SEQ_OPEN);
        end
    end

    // R7: leaving unlock mode mid-sequence returns to the start
    a_r7_abandon: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_GOT_FIRST && mode_e != MODE_UNLOCK)
        |=> state_q == SEQ_WAIT_FIRST);

    // R4: a short pulse never leaves a partial sequence behind
    a_r4_short_resets: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && !long_enough && state_q != SEQ_OPEN)
        |=> state_q == SEQ_WAIT_FIRST);

endmodule

// File: rtl/pe_unlock_gate.sv
module pe_unlock_gate
    import pe_unlock_pkg::*;
#(
    parameter int         DATA_W     = 8,
    parameter int         MIN_WIDTH  = 25,
    parameter logic [7:0] KEY_FIRST  = 8'h55,
    parameter logic [7:0] KEY_SECOND = 8'hAA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic [DATA_W-1:0] data_in,
    input  logic [1:0]        mode,
    output logic              access_en
);

    logic              rise;
    logic              fall;
    logic              long_enough;
    logic [DATA_W-1:0] key_byte;

    pe_strobe_edge #(.DATA_W(DATA_W)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe   (strobe),
        .data_in  (data_in),
        .rise     (rise),
        .fall     (fall),
        .key_byte (key_byte)
    );

    pe_width_meter #(.MIN_WIDTH(MIN_WIDTH)) u_width (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise        (rise),
        .strobe      (strobe),
        .long_enough (long_enough)
    );

    pe_key_seq #(
        .DATA_W     (DATA_W),
        .KEY_FIRST  (KEY_FIRST),
        .KEY_SECOND (KEY_SECOND)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .fall        (fall),
        .long_enough (long_enough),
        .key_byte    (key_byte),
        .mode        (mode),
        .access_en   (access_en)
    );

    // R6: lock mode drops the flag at the next edge
    a_r6_lock_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10) |=> !access_en);

    // R8: an open flag persists unless lock is selected
    a_r8_hold_open: assert property (@(posedge clk) disable iff (!rst_n)
        (access_en && mode != 2'b10) |=> access_en);

    // R2: the flag rises only right after a long second-key falling edge in unlock mode
    a_r2_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(access_en) |-> ($past(fall) && $past(long_enough)
                              && $past(key_byte) == DATA_W'(KEY_SECOND)
                              && $past(mode) == 2'b01));

endmodule

// File: tb/pe_unlock_gate_tb.sv
`timescale 1ns/1ps
module pe_unlock_gate_tb;

    localparam int MINW = 25;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strobe = 1'b0;
    logic [7:0] data_in = 8'h00;
    logic [1:0] mode = 2'b00;
    logic       access_en;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pe_unlock_gate u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe    (strobe),
        .data_in   (data_in),
        .mode      (mode),
        .access_en (access_en)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s access_en actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; strobe = 1'b0; mode = 2'b00; data_in = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Pulse of 'width' clocks: byte b_rise at the rising edge, b_mid afterwards.
    task automatic pulse_mid(input logic [7:0] b_rise, input logic [7:0] b_mid, input int width);
        strobe = 1'b1; data_in = b_rise;
        @(negedge clk);
        data_in = b_mid;
        repeat (width - 1) @(negedge clk);
        strobe = 1'b0; data_in = 8'h00;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic pulse(input logic [7:0] b, input int width);
        pulse_mid(b, b, width);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 during reset", access_en, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", access_en, 1'b0);
        mode = 2'b01;
        pulse(8'hAA, MINW);
        check("R1 lone second key", access_en, 1'b0);
    endtask

    task automatic t_unlock();
        do_reset();
        mode = 2'b01;
        pulse(8'h55, MINW);
        check("R2 after first key", access_en, 1'b0);
        strobe = 1'b1; data_in = 8'hAA;
        repeat (MINW) @(negedge clk);
        strobe = 1'b0;
        check("R2 before falling edge", access_en, 1'b0);
        @(negedge clk);
        check("R2 open after second fall", access_en, 1'b1);
    endtask

    task automatic t_latch();
        do_reset();
        mode = 2'b01;
        pulse_mid(8'h55, 8'h12, MINW);
        pulse_mid(8'hAA, 8'h55, MINW);
        check("R3 rising-edge bytes open", access_en, 1'b1);
        do_reset();
        mode = 2'b01;
        pulse_mid(8'h33, 8'h55, MINW);
        pulse(8'hAA, MINW);
        check("R3 late first byte ignored", access_en, 1'b0);
    endtask

    task automatic t_width();
        do_reset();
        mode = 2'b01;
        pulse(8'h55, MINW - 1);
        pulse(8'hAA, MINW);
        check("R4 short first key", access_en, 1'b0);
        pulse(8'h55, MINW);
        pulse(8'hAA, MINW - 1);
        check("R4 short second key", access_en, 1'b0);
        pulse(8'hAA, MINW);
        check("R4 short resets start", access_en, 1'b0);
        pulse(8'h55, MINW);
        pulse(8'hAA, MINW);
        check("R4 exact width accepted", access_en, 1'b1);
    endtask

    task automatic t_wrong();
        do_reset();
        mode = 2'b01;
        pulse(8'h55, MINW);
        pulse(8'h33, MINW);
        pulse(8'hAA, MINW);
        check("R5 wrong byte resets", access_en, 1'b0);
        pulse(8'h55, MINW);
        pulse(8'h55, MINW);
        pulse(8'hAA, MINW);
        check("R5 repeated first key restarts", access_en, 1'b1);
    endtask

    task automatic t_lock();
        mode = 2'b10;
        @(negedge clk);
        check("R6 lock clears next edge", access_en, 1'b0);
        mode = 2'b01;
        @(negedge clk);
        pulse(8'hAA, MINW);
        check("R6 relock needs full key", access_en, 1'b0);
    endtask

    task automatic t_abandon();
        do_reset();
        mode = 2'b01;
        pulse(8'h55, MINW);
        mode = 2'b00;
        @(negedge clk);
        mode = 2'b01;
        @(negedge clk);
        pulse(8'hAA, MINW);
        check("R7 abandoned sequence", access_en, 1'b0);
    endtask

    task automatic t_hold();
        do_reset();
        mode = 2'b01;
        pulse(8'h55, MINW);
        pulse(8'hAA, MINW);
        pulse(8'h33, MINW);
        pulse(8'h12, 3);
        check("R8 open through pulses", access_en, 1'b1);
        mode = 2'b00;
        repeat (10) @(negedge clk);
        mode = 2'b11;
        repeat (10) @(negedge clk);
        check("R8 open through hold modes", access_en, 1'b1);
    endtask

    task automatic t_ignored();
        do_reset();
        mode = 2'b00;
        pulse(8'h55, MINW);
        mode = 2'b01;
        @(negedge clk);
        pulse(8'hAA, MINW);
        check("R9 first key outside unlock ignored", access_en, 1'b0);
        pulse(8'h55, MINW);
        mode = 2'b11;
        pulse(8'hAA, MINW);
        mode = 2'b01;
        check("R9 second key outside unlock ignored", access_en, 1'b0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        t_reset();
        t_unlock();
        t_latch();
        t_width();
        t_wrong();
        t_lock();
        t_abandon();
        t_hold();
        t_ignored();
        done = 1'b1;
        summary();
        $finish;
    end

endmodule